// File: doc/BRIEF.md
# Settable Time-of-Day Counter

This block keeps the time of day as hours, minutes and seconds on a 24-hour dial. It runs from a fast system clock and advances by one second on every cycle where the one-per-second enable is high. Each field comes out as 8-bit packed BCD: tens digit in bits [7:4], units digit in bits [3:0]. The three keys (set, change, confirm) are single-cycle pulses that have already been debounced.

Setting is done in place. A set pulse leaves normal running and puts a field cursor on the hour. Further set pulses move the cursor hour, then minute, then second, then back to hour. A change pulse bumps the field under the cursor. A confirm pulse returns to running. Confirming while the cursor sits on seconds also zeroes the seconds, so the clock can be aligned exactly to an outside reference. Keys act only while the 4-bit mode input selects timekeeping (value 0). The controller has four states: RUN, EDIT_HR, EDIT_MIN and EDIT_SEC. Its transitions are:

- enter: RUN to EDIT_HR on set.
- step: EDIT_HR to EDIT_MIN, EDIT_MIN to EDIT_SEC, and EDIT_SEC to EDIT_HR, each on set.
- commit: any EDIT state to RUN on confirm.
- reset: any state to RUN.

Top module: `tod_counter`

## Requirements
- R1: A synchronous active-high reset loads 00:00:00 and puts the block in running state, from any state. After reset is released, the next enable advances the time.
- R2: In running state each cycle with the one-second enable high advances the seconds by one in BCD. Seconds 59 wraps to 00 and carries one into the minutes.
- R3: Minutes 59 wraps to 00 and carries into the hours when seconds wrap. At 23:59:59 one enable gives 00:00:00.
- R4: In running state, with no enable, the time holds. Change and confirm pulses have no effect on it.
- R5: A set pulse in running state with mode 0 enters editing with the cursor on the hour. While editing, the enable is ignored and the fields change only by keys.
- R6: While editing, each set pulse moves the cursor hour to minute to second and back to hour.
- R7: While editing, a change pulse increments only the selected field. Hours wrap 23 to 00 and minutes and seconds wrap 59 to 00, with no carry into any other field.
- R8: A confirm pulse with the cursor on the hour or the minute returns to running and keeps all three fields. An enable on the cycle right after the confirm already counts.
- R9: A confirm pulse with the cursor on the seconds sets the seconds to 00 and returns to running.
- R10: When mode is not 0, all three keys are ignored. The state and the cursor stay as they are. Counting in running state continues.
- R11: When keys coincide in one cycle, confirm wins over set, and set wins over change. The losing keys have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| key_set | input | 1 | Enter setting / move field cursor |
| key_change | input | 1 | Increment the selected field |
| key_confirm | input | 1 | Commit edits and resume running |
| mode | input | 4 | Operating mode; keys act only at 0 |
| hour_bcd | output | 8 | Hours, packed BCD 00..23 |
| min_bcd | output | 8 | Minutes, packed BCD 00..59 |
| sec_bcd | output | 8 | Seconds, packed BCD 00..59 |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. This holds for a count step, a carry across all three fields, a field bump, the seconds clear on confirm, and a state change, because the time fields and the state register all sit one flop from the inputs. The bench applies each stimulus at a falling edge and compares the three fields at the next falling edge, after the single rising edge in between. Cursor position and running/editing state have no port of their own. The bench infers them from the field that the next change pulse moves, and from whether a following enable counts.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_EDIT_HR  = 2'd1,
        ST_EDIT_MIN = 2'd2,
        ST_EDIT_SEC = 2'd3
    } tod_state_e;

    localparam int NUM_FIELDS = 3;
    localparam int FLD_SEC    = 0;
    localparam int FLD_MIN    = 1;
    localparam int FLD_HR     = 2;

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field #(
    parameter int LIMIT = 59
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inc,
    input  logic       clr,
    output logic [7:0] value
);
    localparam logic [7:0] LIM_BCD = tod_pkg::to_bcd(LIMIT);

    logic [7:0] nxt;

    always_comb begin
        if (value == LIM_BCD)
            nxt = 8'h00;
        else if (value[3:0] == 4'd9)
            nxt = {value[7:4] + 4'd1, 4'd0};
        else
            nxt = {value[7:4], value[3:0] + 4'd1};
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            value <= 8'h00;
        else if (inc)
            value <= nxt;
    end

endmodule

// File: rtl/tod_ctrl.sv
module tod_ctrl
    import tod_pkg::*;
#(
    parameter int MODE_W        = 4,
    parameter int TIMEKEEP_MODE = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  key_set,
    input  logic                  key_change,
    input  logic                  key_confirm,
    input  logic [MODE_W-1:0]     mode,
    output tod_state_e            state_o,
    output logic                  run_tick,
    output logic [NUM_FIELDS-1:0] edit_inc,
    output logic                  sec_clr
);
    tod_state_e state, state_nxt;
    logic keys_on, do_confirm, do_set, do_change;

    assign keys_on    = (mode == MODE_W'(TIMEKEEP_MODE));
    assign do_confirm = keys_on && key_confirm;
    assign do_set     = keys_on && key_set && !key_confirm;
    assign do_change  = keys_on && key_change && !key_set && !key_confirm;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_RUN;
        else
            state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:      if (do_set)          state_nxt = ST_EDIT_HR;
            ST_EDIT_HR:  if (do_confirm)      state_nxt = ST_RUN;
                         else if (do_set)     state_nxt = ST_EDIT_MIN;
            ST_EDIT_MIN: if (do_confirm)      state_nxt = ST_RUN;
                         else if (do_set)     state_nxt = ST_EDIT_SEC;
            ST_EDIT_SEC: if (do_confirm)      state_nxt = ST_RUN;
                         else if (do_set)     state_nxt = ST_EDIT_HR;
            default:                          state_nxt = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        run_tick = 1'b0;
        edit_inc = '0;
        sec_clr  = 1'b0;
        unique case (state)
            ST_RUN:      run_tick         = tick;
            ST_EDIT_HR:  edit_inc[FLD_HR]  = do_change;
            ST_EDIT_MIN: edit_inc[FLD_MIN] = do_change;
            ST_EDIT_SEC: begin
                edit_inc[FLD_SEC] = do_change;
                sec_clr           = do_confirm;
            end
            default: ;
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int MODE_W        = 4,
    parameter int TIMEKEEP_MODE = 0,
    parameter int HOURS_PER_DAY = 24,
    parameter int UNITS_PER_MIN = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              key_set,
    input  logic              key_change,
    input  logic              key_confirm,
    input  logic [MODE_W-1:0] mode,
    output logic [7:0]        hour_bcd,
    output logic [7:0]        min_bcd,
    output logic [7:0]        sec_bcd
);
    localparam logic [7:0] SUB_LIM_BCD = to_bcd(UNITS_PER_MIN - 1);

    tod_state_e                      cur_state;
    logic                            run_tick;
    logic                            sec_clr;
    logic [NUM_FIELDS-1:0]           edit_inc;
    logic [NUM_FIELDS-1:0]           carry;
    logic [NUM_FIELDS-1:0]           fld_inc;
    logic [NUM_FIELDS-1:0][7:0]      fval;

    tod_ctrl #(
        .MODE_W        (MODE_W),
        .TIMEKEEP_MODE (TIMEKEEP_MODE)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_1hz),
        .key_set     (key_set),
        .key_change  (key_change),
        .key_confirm (key_confirm),
        .mode        (mode),
        .state_o     (cur_state),
        .run_tick    (run_tick),
        .edit_inc    (edit_inc),
        .sec_clr     (sec_clr)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam int LIM = (i == FLD_HR) ? HOURS_PER_DAY - 1 : UNITS_PER_MIN - 1;

        if (i == 0) begin : g_first
            assign carry[i] = run_tick;
        end else begin : g_chain
            assign carry[i] = carry[i-1] && (fval[i-1] == SUB_LIM_BCD);
        end

        assign fld_inc[i] = carry[i] || edit_inc[i];

        tod_bcd_field #(
            .LIMIT (LIM)
        ) u_fld (
            .clk   (clk),
            .rst   (rst),
            .inc   (fld_inc[i]),
            .clr   ((i == FLD_SEC) ? sec_clr : 1'b0),
            .value (fval[i])
        );
    end

    assign sec_bcd  = fval[FLD_SEC];
    assign min_bcd  = fval[FLD_MIN];
    assign hour_bcd = fval[FLD_HR];

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
    import tod_pkg::*;
#(
    parameter int MODE_W        = 4,
    parameter int TIMEKEEP_MODE = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              key_set,
    input logic              key_change,
    input logic              key_confirm,
    input logic [MODE_W-1:0] mode,
    input logic [7:0]        hour_bcd,
    input logic [7:0]        min_bcd,
    input logic [7:0]        sec_bcd,
    input tod_state_e        cur_state
);
    logic keys_on;
    assign keys_on = (mode == MODE_W'(TIMEKEEP_MODE));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (hour_bcd == 8'h00 && min_bcd == 8'h00 && sec_bcd == 8'h00 && cur_state == ST_RUN));

    a_r2_tick_moves_sec: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_RUN && tick_1hz) |=> !$stable(sec_bcd));

    a_r3_day_wrap: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_RUN && tick_1hz && hour_bcd == 8'h23 && min_bcd == 8'h59 && sec_bcd == 8'h59)
        |=> (hour_bcd == 8'h00 && min_bcd == 8'h00 && sec_bcd == 8'h00));

    a_r4_run_hold: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_RUN && !tick_1hz) |=> ($stable(hour_bcd) && $stable(min_bcd) && $stable(sec_bcd)));

    a_r5_edit_freeze: assert property (@(posedge clk) disable iff (rst)
        (cur_state != ST_RUN && !(keys_on && (key_change || key_confirm)))
        |=> ($stable(hour_bcd) && $stable(min_bcd) && $stable(sec_bcd)));

    a_r6_cursor_step: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_EDIT_HR && keys_on && key_set && !key_confirm) |=> (cur_state == ST_EDIT_MIN));

    a_r7_bcd_range: assert property (@(posedge clk) disable iff (rst)
        (hour_bcd <= 8'h23 && min_bcd <= 8'h59 && sec_bcd <= 8'h59 &&
         hour_bcd[3:0] <= 4'd9 && min_bcd[3:0] <= 4'd9 && sec_bcd[3:0] <= 4'd9));

    a_r9_sec_zero: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_EDIT_SEC && keys_on && key_confirm) |=> (sec_bcd == 8'h00 && cur_state == ST_RUN));

    a_r10_mode_lock: assert property (@(posedge clk) disable iff (rst)
        !keys_on |=> $stable(cur_state));

endmodule

bind tod_counter tod_counter_chk #(
    .MODE_W        (MODE_W),
    .TIMEKEEP_MODE (TIMEKEEP_MODE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_1hz    (tick_1hz),
    .key_set     (key_set),
    .key_change  (key_change),
    .key_confirm (key_confirm),
    .mode        (mode),
    .hour_bcd    (hour_bcd),
    .min_bcd     (min_bcd),
    .sec_bcd     (sec_bcd),
    .cur_state   (cur_state)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb;

    typedef struct packed {
        logic       tk;
        logic       st;
        logic       ch;
        logic       cf;
        logic [3:0] md;
        logic [7:0] eh;
        logic [7:0] em;
        logic [7:0] es;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,4'd0,8'h00,8'h00,8'h01},  // R2 tick
        '{1'b0,1'b0,1'b0,1'b0,4'd0,8'h00,8'h00,8'h01},  // R4 idle
        '{1'b0,1'b1,1'b0,1'b0,4'd0,8'h00,8'h00,8'h01},  // R5 enter edit
        '{1'b1,1'b0,1'b0,1'b0,4'd0,8'h00,8'h00,8'h01},  // R5 tick ignored
        '{1'b0,1'b0,1'b1,1'b0,4'd0,8'h01,8'h00,8'h01},  // R7 hour bump
        '{1'b0,1'b1,1'b0,1'b0,4'd0,8'h01,8'h00,8'h01},  // R6 to minute
        '{1'b0,1'b0,1'b1,1'b0,4'd0,8'h01,8'h01,8'h01},  // R7 minute bump
        '{1'b0,1'b1,1'b0,1'b0,4'd0,8'h01,8'h01,8'h01},  // R6 to second
        '{1'b0,1'b0,1'b1,1'b0,4'd0,8'h01,8'h01,8'h02},  // R7 second bump
        '{1'b0,1'b1,1'b0,1'b0,4'd0,8'h01,8'h01,8'h02},  // R6 wrap to hour
        '{1'b0,1'b0,1'b1,1'b0,4'd0,8'h02,8'h01,8'h02},  // R6 hour selected
        '{1'b0,1'b1,1'b1,1'b0,4'd0,8'h02,8'h01,8'h02},  // R11 set over change
        '{1'b0,1'b0,1'b1,1'b0,4'd0,8'h02,8'h02,8'h02},  // R11 cursor on minute
        '{1'b0,1'b1,1'b0,1'b1,4'd0,8'h02,8'h02,8'h02},  // R11 confirm over set
        '{1'b1,1'b0,1'b0,1'b0,4'd0,8'h02,8'h02,8'h03},  // R8 count resumes
        '{1'b0,1'b1,1'b0,1'b0,4'd1,8'h02,8'h02,8'h03},  // R10 set ignored
        '{1'b1,1'b0,1'b0,1'b0,4'd1,8'h02,8'h02,8'h04},  // R10 still counts
        '{1'b0,1'b0,1'b1,1'b1,4'd0,8'h02,8'h02,8'h04}   // R4 keys in run
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       key_set = 1'b0;
    logic       key_change = 1'b0;
    logic       key_confirm = 1'b0;
    logic [3:0] mode = 4'd0;
    logic [7:0] hour_bcd, min_bcd, sec_bcd;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tod_counter u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_1hz    (tick_1hz),
        .key_set     (key_set),
        .key_change  (key_change),
        .key_confirm (key_confirm),
        .mode        (mode),
        .hour_bcd    (hour_bcd),
        .min_bcd     (min_bcd),
        .sec_bcd     (sec_bcd)
    );

    task automatic check(input string req, input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        n_checks++;
        if ({hour_bcd, min_bcd, sec_bcd} !== {h, m, s}) begin
            n_fail++;
            $display("FAIL %s: got %h:%h:%h expected %h:%h:%h", req,
                     hour_bcd, min_bcd, sec_bcd, h, m, s);
        end
    endtask

    // drive at a falling edge, one rising edge follows, return at next falling edge
    task automatic cyc(input logic tk, input logic st, input logic ch, input logic cf, input logic [3:0] md);
        tick_1hz = tk; key_set = st; key_change = ch; key_confirm = cf; mode = md;
        @(negedge clk);
        tick_1hz = 1'b0; key_set = 1'b0; key_change = 1'b0; key_confirm = 1'b0; mode = 4'd0;
    endtask

    task automatic repeat_cyc(input int n, input logic tk, input logic ch);
        for (int k = 0; k < n; k++) cyc(tk, 1'b0, ch, 1'b0, 4'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 8'h00, 8'h00, 8'h00);

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].tk, VECS[i].st, VECS[i].ch, VECS[i].cf, VECS[i].md);
            check($sformatf("vector %0d (R2..R11)", i), VECS[i].eh, VECS[i].em, VECS[i].es);
        end

        // R9: confirm on seconds zeroes them, then running again
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'd0);
        check("R9 seconds cleared", 8'h02, 8'h02, 8'h00);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
        check("R9 running after clear", 8'h02, 8'h02, 8'h01);

        // R10: nonzero mode in edit leaves editing in place
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'd2);
        check("R10 confirm ignored in edit", 8'h02, 8'h02, 8'h01);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
        check("R10 still editing hour", 8'h03, 8'h02, 8'h01);

        // R1: reset from editing returns to running
        do_reset();
        check("R1 reset from edit", 8'h00, 8'h00, 8'h00);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
        check("R1 running after reset", 8'h00, 8'h00, 8'h01);

        // R7: wraps without carry
        do_reset();
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        repeat_cyc(23, 1'b0, 1'b1);
        check("R7 hour at 23", 8'h23, 8'h00, 8'h00);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
        check("R7 hour wrap", 8'h00, 8'h00, 8'h00);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        repeat_cyc(59, 1'b0, 1'b1);
        check("R7 minute at 59", 8'h00, 8'h59, 8'h00);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
        check("R7 minute wrap no carry", 8'h00, 8'h00, 8'h00);
        repeat_cyc(59, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        repeat_cyc(58, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        repeat_cyc(23, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'd0);
        check("R8 confirm on hour keeps fields", 8'h23, 8'h59, 8'h58);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
        check("R2 step to 59", 8'h23, 8'h59, 8'h59);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
        check("R3 day wrap", 8'h00, 8'h00, 8'h00);

        // R2: seconds carry into minutes
        repeat_cyc(59, 1'b1, 1'b0);
        check("R2 seconds at 59", 8'h00, 8'h00, 8'h59);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
        check("R2 minute carry", 8'h00, 8'h01, 8'h00);

        // R3: minute carry into hour
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        repeat_cyc(58, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        repeat_cyc(59, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'd0);
        check("R8 edited 00:59:59", 8'h00, 8'h59, 8'h59);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
        check("R3 hour carry", 8'h01, 8'h00, 8'h00);

        finish_run();
    end

endmodule